// File: doc/BRIEF.md
# Nine-bit Multidrop Receive Status and Transmit Packing Unit

This block sits between the serial engine of a UART and its FIFOs when the UART runs on a multidrop bus with 9-bit characters. On the receive side it takes each completed character and its line error flags. It forms the character word and the per-character status word that go into the receive FIFO, and it pushes them one cycle later.

In 9-bit mode the ninth data bit replaces the parity-error status bit. The error summary bit then reflects only overrun, framing and break. This lets software tell an address interrupt from an error interrupt.

The unit also keeps three interrupt sources:
- a line-error source;
- an address source, for characters whose ninth bit is set;
- a match source, for characters equal to one of a set of programmable 9-bit characters.

Each source is flagged in the same cycle its character enters the FIFO. The sources stay flagged until the interrupt status is read.

On the transmit side the unit joins a staged ninth bit with a later 8-bit data write, giving one 9-bit transmit FIFO entry. While 9-bit mode is on, in-band software flow control is reported as not allowed, because its character registers serve as match registers.

Top module: `nbm_unit`

## Requirements
- R1: With `cfg_ninebit`=0, a character on `rx_valid` is pushed (`fifo_push`=1) exactly one cycle later. `fifo_char[8]` is 0, status bit 2 equals `rx_parity_err`, and status bit 7 is the OR of parity error, overrun, framing and break.
- R2: With `cfg_ninebit`=1, all 9 bits of `rx_char` appear on `fifo_char`, and status bit 2 carries `rx_char[8]`. `rx_parity_err` is ignored.
- R3: The status word has this layout, in both modes:
  - bit 0: always 1;
  - bit 1: overrun;
  - bit 3: framing error;
  - bit 4: break;
  - bits 6:5: 0.
  In 9-bit mode, bit 7 is the OR of overrun, framing and break only.
- R4: With `cfg_err_irq_en`=1, a character with any line error sets `irq_src[0]` in the cycle it is pushed. With the enable at 0, no error source is flagged.
- R5: With `cfg_ninebit`=1 and `cfg_addr_irq_en`=1, a character with `rx_char[8]`=1 sets `irq_src[1]` in the cycle it is pushed. In any other case the address source is not flagged.
- R6: With `cfg_ninebit`=1, a character equal on all 9 bits to any enabled match register sets `irq_src[2]` in the cycle it is pushed. When only the match source is pending, `irq_id` = 5.
- R7: A match register whose enable bit is 0 never matches. No match is flagged when `cfg_ninebit`=0.
- R8: A character may qualify for several sources at once; each of them is flagged. `irq_id` is:
  - 1 whenever the error or address source is pending (level 1 ranks above level 5);
  - 5 when only the match source is pending;
  - 0 when nothing is pending.
- R9: Pending sources stay set until a cycle with `irq_status_rd`=1, which clears all of them. A source set in that same cycle remains set.
- R10: `inband_flow_ok` is 1 exactly when `cfg_ninebit` is 0.
- R11: In 9-bit mode, `tx_data_wr` pushes `{staged bit, tx_data}` on `tx_word`, with `tx_push`=1 one cycle later. The staged bit holds until it is rewritten. A stage write in the same cycle as a data write takes effect only for later data writes.
- R12: With `cfg_ninebit`=0, `tx_word[8]` is 0 on every transmit push, and a stage write alone never pushes.
- R13: While `rst` is high, and right after it, `fifo_push`, `tx_push`, `irq_src` and `irq_id` are 0 and the staged bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ninebit | input | 1 | 9-bit mode enable |
| cfg_addr_irq_en | input | 1 | Address interrupt enable |
| cfg_err_irq_en | input | 1 | Line-error interrupt enable |
| cfg_match_en | input | N_MATCH | Per-register match enables |
| cfg_match_chars | input | N_MATCH*9 | Match characters, register i in bits [9i+8:9i] |
| rx_valid | input | 1 | Completed receive character strobe |
| rx_char | input | 9 | Received character (bit 8 is the ninth bit) |
| rx_parity_err | input | 1 | Parity error from the deserializer |
| rx_overrun | input | 1 | Overrun flag |
| rx_framing | input | 1 | Framing error flag |
| rx_break | input | 1 | Break flag |
| irq_status_rd | input | 1 | Interrupt status read strobe, clears pending sources |
| tx_stage_wr | input | 1 | Write strobe for the staged ninth bit |
| tx_stage_bit | input | 1 | Ninth-bit value to stage |
| tx_data_wr | input | 1 | 8-bit transmit data write strobe |
| tx_data | input | 8 | Transmit data byte |
| fifo_push | output | 1 | Receive FIFO push |
| fifo_char | output | 9 | Character word for the receive FIFO |
| fifo_status | output | 8 | Status word for the receive FIFO |
| tx_push | output | 1 | Transmit FIFO push |
| tx_word | output | 9 | 9-bit transmit FIFO entry |
| irq_src | output | 3 | Pending sources: bit 0 error, bit 1 address, bit 2 match |
| irq_id | output | 3 | Highest pending level: 0 none, 1, or 5 |
| inband_flow_ok | output | 1 | In-band flow control allowed |

## Verification
The bench builds the unit with its defaults: an 8-bit data byte and four match registers. All four registers are loaded.

One register holds a value that also carries the ninth bit but has its enable cleared. This tests the disabled-register rule against an address character. The last register sits at the top of the index range, so the generated comparator loop is covered at both ends.

Mode switches between normal and 9-bit operation exercise:
- the reuse of status bit 2;
- the narrower error summary;
- the case where a read and a new interrupt land in the same cycle.

// File: rtl/nbm_pkg.sv
package nbm_pkg;

    localparam int unsigned STAT_W = 8;

    typedef struct packed {
        logic       summary;
        logic [1:0] zero;
        logic       brk;
        logic       framing;
        logic       bit2;
        logic       overrun;
        logic       present;
    } rx_stat_t;

    typedef struct packed {
        logic match;
        logic addr;
        logic err;
    } irq_src_t;

    typedef enum logic [2:0] {
        IRQ_NONE = 3'd0,
        IRQ_LVL1 = 3'd1,
        IRQ_LVL5 = 3'd5
    } irq_id_e;

    function automatic rx_stat_t make_status(
        input logic mode9,
        input logic ninth,
        input logic par,
        input logic ovr,
        input logic frm,
        input logic brk
    );
        rx_stat_t s;
        s.present = 1'b1;
        s.overrun = ovr;
        s.bit2    = mode9 ? ninth : par;
        s.framing = frm;
        s.brk     = brk;
        s.zero    = 2'b00;
        s.summary = ovr | frm | brk | (~mode9 & par);
        return s;
    endfunction

endpackage

// File: rtl/nbm_match.sv
module nbm_match #(
    parameter int CHAR_W  = 9,
    parameter int N_MATCH = 4
) (
    input  logic                      mode9,
    input  logic [CHAR_W-1:0]         rx_char,
    input  logic [N_MATCH-1:0]        match_en,
    input  logic [N_MATCH*CHAR_W-1:0] match_chars,
    output logic                      hit
);
    logic [N_MATCH-1:0] slot_eq;

    for (genvar i = 0; i < N_MATCH; i++) begin : g_slot
        assign slot_eq[i] = match_en[i] &&
                            (match_chars[i*CHAR_W +: CHAR_W] == rx_char);
    end

    assign hit = mode9 && (|slot_eq);

endmodule

// File: rtl/nbm_rx_path.sv
module nbm_rx_path
    import nbm_pkg::*;
#(
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode9,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_parity_err,
    input  logic              rx_overrun,
    input  logic              rx_framing,
    input  logic              rx_break,
    output logic              ev_err,
    output logic              ev_addr,
    output logic              push_q,
    output logic [CHAR_W-1:0] char_q,
    output rx_stat_t          stat_q
);
    localparam int MSB = CHAR_W - 1;

    logic [CHAR_W-1:0] char_d;
    rx_stat_t          stat_d;

    always_comb begin
        char_d      = rx_char;
        char_d[MSB] = mode9 & rx_char[MSB];
        stat_d      = make_status(mode9, rx_char[MSB], rx_parity_err,
                                  rx_overrun, rx_framing, rx_break);
        ev_err      = rx_valid & stat_d.summary;
        ev_addr     = rx_valid & mode9 & rx_char[MSB];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            push_q <= 1'b0;
            char_q <= '0;
            stat_q <= '0;
        end else begin
            push_q <= rx_valid;
            if (rx_valid) begin
                char_q <= char_d;
                stat_q <= stat_d;
            end
        end
    end

    // R2: ninth bit lands in status bit 2 in 9-bit mode
    a_r2_ninth_in_bit2: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && mode9) |=> (stat_q.bit2 == $past(rx_char[MSB])));

    // R3: the summary ignores the ninth bit in 9-bit mode
    a_r3_summary_errors_only: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && mode9) |=>
        (stat_q.summary == ($past(rx_overrun) | $past(rx_framing) | $past(rx_break))));

    // R1: bit 8 of the stored character is cleared outside 9-bit mode
    a_r1_msb_cleared: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !mode9) |=> (push_q && char_q[MSB] == 1'b0));

endmodule

// File: rtl/nbm_irq.sv
module nbm_irq
    import nbm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     set_err,
    input  logic     set_addr,
    input  logic     set_match,
    input  logic     clr,
    output irq_src_t src,
    output irq_id_e  id
);
    irq_src_t setv;

    always_comb begin
        setv.err   = set_err;
        setv.addr  = set_addr;
        setv.match = set_match;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src <= '0;
        end else if (clr) begin
            src <= setv;
        end else begin
            src <= src | setv;
        end
    end

    always_comb begin
        if (src.err || src.addr) begin
            id = IRQ_LVL1;
        end else if (src.match) begin
            id = IRQ_LVL5;
        end else begin
            id = IRQ_NONE;
        end
    end

    // R9: a read with no new event leaves nothing pending
    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_err && !set_addr && !set_match) |=> (src == '0));

    // R9: without a read, pending sources persist
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((src & $past(src)) == $past(src)));

    // R8: an address event always ends at level 1
    a_r8_addr_level1: assert property (@(posedge clk) disable iff (rst)
        set_addr |=> (id == IRQ_LVL1));

endmodule

// File: rtl/nbm_tx_pack.sv
module nbm_tx_pack #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode9,
    input  logic              stage_wr,
    input  logic              stage_bit,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data,
    output logic              push_q,
    output logic [DATA_W:0]   word_q
);
    logic staged;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= 1'b0;
            push_q <= 1'b0;
            word_q <= '0;
        end else begin
            push_q <= data_wr;
            if (data_wr) begin
                word_q <= {mode9 & staged, data};
            end
            if (stage_wr) begin
                staged <= stage_bit;
            end
        end
    end

    // R11: a data write produces a push carrying that byte
    a_r11_push_byte: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> (push_q && word_q[DATA_W-1:0] == $past(data)));

    // R12: a stage write alone never pushes
    a_r12_stage_only: assert property (@(posedge clk) disable iff (rst)
        (stage_wr && !data_wr) |=> !push_q);

endmodule

// File: rtl/nbm_unit.sv
module nbm_unit
    import nbm_pkg::*;
#(
    parameter  int DATA_W  = 8,
    parameter  int N_MATCH = 4,
    localparam int CHAR_W  = DATA_W + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_ninebit,
    input  logic                      cfg_addr_irq_en,
    input  logic                      cfg_err_irq_en,
    input  logic [N_MATCH-1:0]        cfg_match_en,
    input  logic [N_MATCH*CHAR_W-1:0] cfg_match_chars,
    input  logic                      rx_valid,
    input  logic [CHAR_W-1:0]         rx_char,
    input  logic                      rx_parity_err,
    input  logic                      rx_overrun,
    input  logic                      rx_framing,
    input  logic                      rx_break,
    input  logic                      irq_status_rd,
    input  logic                      tx_stage_wr,
    input  logic                      tx_stage_bit,
    input  logic                      tx_data_wr,
    input  logic [DATA_W-1:0]         tx_data,
    output logic                      fifo_push,
    output logic [CHAR_W-1:0]         fifo_char,
    output logic [STAT_W-1:0]         fifo_status,
    output logic                      tx_push,
    output logic [CHAR_W-1:0]         tx_word,
    output logic [2:0]                irq_src,
    output logic [2:0]                irq_id,
    output logic                      inband_flow_ok
);
    logic     ev_err;
    logic     ev_addr;
    logic     hit;
    rx_stat_t stat_q;
    irq_src_t src;
    irq_id_e  id;

    nbm_match #(.CHAR_W(CHAR_W), .N_MATCH(N_MATCH)) u_match (
        .mode9       (cfg_ninebit),
        .rx_char     (rx_char),
        .match_en    (cfg_match_en),
        .match_chars (cfg_match_chars),
        .hit         (hit)
    );

    nbm_rx_path #(.CHAR_W(CHAR_W)) u_rx (
        .clk           (clk),
        .rst           (rst),
        .mode9         (cfg_ninebit),
        .rx_valid      (rx_valid),
        .rx_char       (rx_char),
        .rx_parity_err (rx_parity_err),
        .rx_overrun    (rx_overrun),
        .rx_framing    (rx_framing),
        .rx_break      (rx_break),
        .ev_err        (ev_err),
        .ev_addr       (ev_addr),
        .push_q        (fifo_push),
        .char_q        (fifo_char),
        .stat_q        (stat_q)
    );

    nbm_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .set_err   (ev_err & cfg_err_irq_en),
        .set_addr  (ev_addr & cfg_addr_irq_en),
        .set_match (rx_valid & hit),
        .clr       (irq_status_rd),
        .src       (src),
        .id        (id)
    );

    nbm_tx_pack #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .mode9     (cfg_ninebit),
        .stage_wr  (tx_stage_wr),
        .stage_bit (tx_stage_bit),
        .data_wr   (tx_data_wr),
        .data      (tx_data),
        .push_q    (tx_push),
        .word_q    (tx_word)
    );

    assign fifo_status    = stat_q;
    assign irq_src        = src;
    assign irq_id         = id;
    assign inband_flow_ok = ~cfg_ninebit;

    // R7: outside 9-bit mode the match source cannot be raised
    a_r7_no_match_normal: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg_ninebit && !irq_status_rd && !irq_src[2]) |=> !irq_src[2]);

    // R5: address source follows an enabled ninth-bit character
    a_r5_addr_flag: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && cfg_ninebit && cfg_addr_irq_en && rx_char[CHAR_W-1]) |=> irq_src[1]);

    // R4: error source follows an enabled errored character
    a_r4_err_flag: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && cfg_err_irq_en && (rx_overrun || rx_framing || rx_break)) |=> irq_src[0]);

endmodule

// File: tb/nbm_unit_tb.sv
module nbm_unit_tb_top;
    localparam int DATA_W  = 8;
    localparam int N_MATCH = 4;
    localparam int CHAR_W  = DATA_W + 1;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      cfg_ninebit = 1'b0;
    logic                      cfg_addr_irq_en = 1'b0;
    logic                      cfg_err_irq_en = 1'b0;
    logic [N_MATCH-1:0]        cfg_match_en = '0;
    logic [N_MATCH*CHAR_W-1:0] cfg_match_chars = '0;
    logic                      rx_valid = 1'b0;
    logic [CHAR_W-1:0]         rx_char = '0;
    logic                      rx_parity_err = 1'b0;
    logic                      rx_overrun = 1'b0;
    logic                      rx_framing = 1'b0;
    logic                      rx_break = 1'b0;
    logic                      irq_status_rd = 1'b0;
    logic                      tx_stage_wr = 1'b0;
    logic                      tx_stage_bit = 1'b0;
    logic                      tx_data_wr = 1'b0;
    logic [DATA_W-1:0]         tx_data = '0;
    logic                      fifo_push;
    logic [CHAR_W-1:0]         fifo_char;
    logic [7:0]                fifo_status;
    logic                      tx_push;
    logic [CHAR_W-1:0]         tx_word;
    logic [2:0]                irq_src;
    logic [2:0]                irq_id;
    logic                      inband_flow_ok;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [16:0]       rx_q[$];
    logic [CHAR_W-1:0] tx_q[$];
    logic [2:0]        exp_src = '0;
    logic              exp_stage = 1'b0;

    always #2.5 clk = ~clk;

    nbm_unit #(.DATA_W(DATA_W), .N_MATCH(N_MATCH)) dut_i (
        .clk(clk), .rst(rst), .cfg_ninebit(cfg_ninebit),
        .cfg_addr_irq_en(cfg_addr_irq_en), .cfg_err_irq_en(cfg_err_irq_en),
        .cfg_match_en(cfg_match_en), .cfg_match_chars(cfg_match_chars),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_parity_err(rx_parity_err),
        .rx_overrun(rx_overrun), .rx_framing(rx_framing), .rx_break(rx_break),
        .irq_status_rd(irq_status_rd), .tx_stage_wr(tx_stage_wr),
        .tx_stage_bit(tx_stage_bit), .tx_data_wr(tx_data_wr), .tx_data(tx_data),
        .fifo_push(fifo_push), .fifo_char(fifo_char), .fifo_status(fifo_status),
        .tx_push(tx_push), .tx_word(tx_word), .irq_src(irq_src), .irq_id(irq_id),
        .inband_flow_ok(inband_flow_ok)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares every push against the expected queue
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (fifo_push) begin
                if (rx_q.size() == 0) begin
                    check(1'b0, "R1 unexpected rx push", {fifo_char, fifo_status}, 0);
                end else begin
                    logic [16:0] e;
                    e = rx_q.pop_front();
                    check({fifo_char, fifo_status} == e, "R1/R2/R3 rx entry",
                          {fifo_char, fifo_status}, e);
                end
            end
            if (tx_push) begin
                if (tx_q.size() == 0) begin
                    check(1'b0, "R12 unexpected tx push", tx_word, 0);
                end else begin
                    logic [CHAR_W-1:0] t;
                    t = tx_q.pop_front();
                    check(tx_word == t, "R11/R12 tx entry", tx_word, t);
                end
            end
        end
    end

    function automatic logic [2:0] exp_id(input logic [2:0] s);
        if (s[0] || s[1]) return 3'd1;
        if (s[2]) return 3'd5;
        return 3'd0;
    endfunction

    // Driver: one receive character, expected entry and interrupt model
    task automatic send(input logic [8:0] ch, input bit par, input bit ovr,
                        input bit frm, input bit brk, input bit rd, input string tag);
        logic [7:0] st;
        logic [8:0] ec;
        logic [2:0] setv;
        bit any_err;
        bit m;
        st = 8'h01;
        st[1] = ovr;
        st[3] = frm;
        st[4] = brk;
        st[2] = cfg_ninebit ? ch[8] : par;
        any_err = ovr | frm | brk | (!cfg_ninebit & par);
        st[7] = any_err;
        ec = cfg_ninebit ? ch : {1'b0, ch[7:0]};
        m = 1'b0;
        for (int i = 0; i < N_MATCH; i++) begin
            if (cfg_ninebit && cfg_match_en[i] &&
                cfg_match_chars[i*CHAR_W +: CHAR_W] == ch) m = 1'b1;
        end
        setv = {m, cfg_ninebit & cfg_addr_irq_en & ch[8], cfg_err_irq_en & any_err};
        exp_src = (rd ? 3'b000 : exp_src) | setv;
        rx_q.push_back({ec, st});
        rx_char = ch; rx_parity_err = par; rx_overrun = ovr;
        rx_framing = frm; rx_break = brk; irq_status_rd = rd; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; irq_status_rd = 1'b0;
        rx_parity_err = 1'b0; rx_overrun = 1'b0; rx_framing = 1'b0; rx_break = 1'b0;
        check(irq_src == exp_src, tag, irq_src, exp_src);
        check(irq_id == exp_id(exp_src), "R8 irq level", irq_id, exp_id(exp_src));
    endtask

    task automatic read_status();
        irq_status_rd = 1'b1;
        @(negedge clk);
        irq_status_rd = 1'b0;
        exp_src = '0;
        check(irq_src == 3'b000, "R9 read clears sources", irq_src, 0);
        check(irq_id == 3'd0, "R9 level after read", irq_id, 0);
    endtask

    task automatic tx_op(input bit sw, input bit sb, input bit dw, input logic [7:0] d);
        if (dw) tx_q.push_back({cfg_ninebit & exp_stage, d});
        tx_stage_wr = sw; tx_stage_bit = sb; tx_data_wr = dw; tx_data = d;
        @(negedge clk);
        tx_stage_wr = 1'b0; tx_data_wr = 1'b0;
        if (sw) exp_stage = sb;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cfg_match_chars = {9'h100, 9'h0FF, 9'h1A5, 9'h055};
        cfg_match_en    = 4'b1101;
        repeat (3) @(negedge clk);
        // R13: reset state
        check(fifo_push == 1'b0 && tx_push == 1'b0, "R13 pushes idle in reset",
              {fifo_push, tx_push}, 0);
        check(irq_src == 3'b000 && irq_id == 3'd0, "R13 no interrupt in reset",
              {irq_src, irq_id}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(inband_flow_ok == 1'b1, "R10 flow control allowed in normal mode",
              inband_flow_ok, 1);

        cfg_err_irq_en  = 1'b1;
        cfg_addr_irq_en = 1'b1;
        send(9'h1A5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1 R4 parity error in normal mode");
        read_status();
        send(9'h055, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 no match in normal mode");

        cfg_ninebit = 1'b1;
        @(negedge clk);
        check(inband_flow_ok == 1'b0, "R10 flow control off in 9-bit mode",
              inband_flow_ok, 0);
        send(9'h1A5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 R7 address char, disabled slot");
        read_status();
        send(9'h055, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 match only gives level 5");
        read_status();
        send(9'h100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 error address and match together");
        read_status();
        send(9'h012, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 overrun summary");
        send(9'h0FF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 set wins over same-cycle read");
        read_status();
        cfg_addr_irq_en = 1'b0;
        send(9'h1A5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 address disabled");
        cfg_err_irq_en = 1'b0;
        send(9'h033, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4 error irq disabled on break");
        send(9'h133, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 parity input ignored");

        // Transmit packing
        tx_op(1'b1, 1'b1, 1'b0, 8'h00);
        check(tx_push == 1'b0, "R12 stage write alone", tx_push, 0);
        tx_op(1'b0, 1'b0, 1'b1, 8'h3C);
        tx_op(1'b0, 1'b0, 1'b1, 8'h41);
        tx_op(1'b1, 1'b0, 1'b1, 8'h7E);
        tx_op(1'b0, 1'b0, 1'b1, 8'h00);
        tx_op(1'b1, 1'b1, 1'b0, 8'h00);
        cfg_ninebit = 1'b0;
        tx_op(1'b0, 1'b0, 1'b1, 8'h22);
        @(negedge clk);
        @(negedge clk);

        check(rx_q.size() == 0, "R1 all rx entries pushed", rx_q.size(), 0);
        check(tx_q.size() == 0, "R11 all tx entries pushed", tx_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule